// File: doc/BRIEF.md
# Horizontal Sync Cleaner

This block takes a raw horizontal sync input, such as a dedicated sync pin or the output of a sync-on-green slicer, and produces two cleaned versions of it. The first is a flywheel copy. A line-period tracker measures the spacing between rising edges. Once the spacing has been steady long enough to declare lock, it emits a fixed-width pulse at every predicted line start. It keeps doing so when input pulses go missing, and it ignores stray pulses. This copy is robust but carries the jitter of its own re-alignment.

The second is a gated copy for clock generation. A raw rising edge passes only if it lands inside a window of ±x clocks around the predicted line start. Edges that land elsewhere are discarded and raise a sticky flag that software may use to spot injected pulses. Two select pins route either the cleaned signal or the untouched raw input to each output.

All pins are plain level signals sampled every clock. No data stream passes through the block, so there is no handshake and no back-pressure. With a 40 MHz clock, one window unit is one clock cycle (25 ns).

Top module: `hsync_cleaner`

## Requirements
- R1: A synchronous active-high reset clears the phase counter, the lock state and the status flag. After reset both outputs read low when their select pins are 1, and `extra_seen` reads 0.
- R2: The line period is the number of clocks between sampled rising edges of `sync_raw`. Lock is declared at the edge that completes the fourth consecutive period lying within ±2 clocks of the period before it. No flywheel pulse appears before that edge.
- R3: While unlocked, every rising edge drives the filtered signal high for 16 cycles, starting at the clock edge that samples the rising edge. During this time the flywheel signal stays low and `extra_seen` stays 0.
- R4: Once locked, the flywheel signal emits a 16-cycle pulse P clocks after the last anchor, and then every P clocks, even with no input. P is the locked period, and the anchor is the last accepted edge or predicted start.
- R5: While locked, a rising edge whose phase (clocks since the anchor) is greater than x and at least P−x is accepted. `win_units` gives x, as 8 bits unsigned. An accepted edge starts both a filtered and a flywheel pulse in that cycle and becomes the new anchor.
- R6: While locked, a rising edge whose phase is greater than x but less than P−x is discarded. It produces no filtered pulse, does not move the anchor, and sets `extra_seen`.
- R7: If a predicted start passed with no accepted edge, a rising edge within x clocks after it is accepted. The edge starts a filtered pulse and re-anchors the phase, but starts no new flywheel pulse. Edges within x clocks after an accepted edge are ignored and not flagged.
- R8: `extra_seen` stays high until `status_clr` is pulsed. If a discard and a clear occur in the same cycle, the flag stays set.
- R9: With `use_filtered`=1, `sync_to_clk` carries the filtered signal; with 0 it carries `sync_raw`. With `use_regen`=1, `sync_to_proc` carries the flywheel signal; with 0 it carries `sync_raw`.
- R10: While locked, a line with no accepted edge leaves the filtered signal low for that line.
- R11: A new trigger during a running pulse restarts the 16-cycle count, so two edges 5 clocks apart give one pulse 21 cycles wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (nominally 40 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| sync_raw | input | 1 | Raw horizontal sync, active high |
| win_units | input | 8 | Window half-width x in clocks |
| use_filtered | input | 1 | 1 selects filtered sync on sync_to_clk, 0 selects raw |
| use_regen | input | 1 | 1 selects flywheel sync on sync_to_proc, 0 selects raw |
| status_clr | input | 1 | One-cycle clear of extra_seen |
| sync_to_clk | output | 1 | Sync for clock generation |
| sync_to_proc | output | 1 | Sync for sync processing |
| extra_seen | output | 1 | Sticky flag for out-of-window edges |

## Verification
Several properties are checked on every cycle:
- Lock never drops once gained, and it only rises on a sampled edge.
- The phase counter never exceeds the locked period.
- The status flag stays quiet before lock and holds until cleared.
- Each stretcher raises its pulse the cycle after a trigger.
- A flywheel pulse only starts while locked.

Only the bench scenarios can show the exact cycle of lock and the position of the window boundaries. The same holds for the re-anchoring after late and early edges, the flywheel spacing across missing lines and the routing of the selects.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  // per-cycle decision of the window gate
  typedef struct packed {
    logic acc;      // edge accepted (re-anchors phase)
    logic acc_pre;  // accepted on the early/on-time side
    logic fly;      // predicted start with no edge
    logic bad;      // edge outside the window
  } hsf_evt_t;
endpackage

// File: rtl/hsf_rise.sv
module hsf_rise (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic rise_o
);
  logic raw_d;

  always_ff @(posedge clk) begin
    if (rst) raw_d <= 1'b0;
    else     raw_d <= raw_i;
  end

  assign rise_o = raw_i & ~raw_d;
endmodule

// File: rtl/hsf_lock.sv
module hsf_lock #(
  parameter int PH_W   = 12,
  parameter int LOCK_N = 4,
  parameter int TOL    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            edge_i,
  input  logic [PH_W-1:0] ph_i,
  output logic            locked_o,
  output logic [PH_W-1:0] period_o
);
  localparam int RUN_W = $clog2(LOCK_N + 1);

  logic             seen_q;
  logic [RUN_W-1:0] run_q;
  logic [PH_W-1:0]  last_q;
  logic [PH_W-1:0]  diff;

  assign diff = (ph_i >= last_q) ? (ph_i - last_q) : (last_q - ph_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      run_q    <= '0;
      last_q   <= '0;
      locked_o <= 1'b0;
      period_o <= '0;
    end else if (edge_i && !locked_o) begin
      if (!seen_q) begin
        seen_q <= 1'b1;
      end else if (run_q == '0 || diff > PH_W'(TOL)) begin
        run_q  <= RUN_W'(1);
        last_q <= ph_i;
      end else begin
        last_q <= ph_i;
        if (run_q == RUN_W'(LOCK_N - 1)) begin
          locked_o <= 1'b1;
          period_o <= ph_i;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);
  assert_lock_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(edge_i));
endmodule

// File: rtl/hsf_track.sv
module hsf_track
  import hsf_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             locked_i,
  input  logic [PH_W-1:0]  period_i,
  input  logic             clr_i,
  output logic [PH_W-1:0]  ph_o,
  output logic             acc_o,
  output logic             regen_trig_o,
  output logic             status_o
);
  localparam int PAD = PH_W + 1 - WIN_W;

  logic [PH_W-1:0] ph_q;
  logic            missed_q;
  logic [PH_W:0]   ph_x, win_x, per_x;
  logic            pre, post;
  hsf_evt_t        ev;

  assign ph_x  = {1'b0, ph_q};
  assign win_x = {{PAD{1'b0}}, win_i};
  assign per_x = {1'b0, period_i};
  assign pre   = (ph_x > win_x) && (ph_x + win_x >= per_x);
  assign post  = (ph_x <= win_x);

  always_comb begin
    ev.acc_pre = locked_i & rise_i & pre;
    ev.acc     = locked_i ? (ev.acc_pre | (rise_i & ~pre & post & missed_q)) : rise_i;
    ev.fly     = locked_i & (ph_q == period_i) & ~ev.acc;
    ev.bad     = locked_i & rise_i & ~(pre | post);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      missed_q <= 1'b0;
      status_o <= 1'b0;
    end else begin
      if (ev.acc || ev.fly)          ph_q <= PH_W'(1);
      else if (ph_q != {PH_W{1'b1}}) ph_q <= ph_q + 1'b1;

      if (ev.acc)           missed_q <= 1'b0;
      else if (ev.fly)      missed_q <= 1'b1;
      else if (ph_x > win_x) missed_q <= 1'b0;

      if (ev.bad)      status_o <= 1'b1;
      else if (clr_i)  status_o <= 1'b0;
    end
  end

  assign ph_o         = ph_q;
  assign acc_o        = ev.acc;
  assign regen_trig_o = ev.acc_pre | ev.fly;

  assert_phase_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    locked_i |-> ph_q <= period_i);
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status_o && !clr_i) |=> status_o);
  assert_status_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!locked_i && !status_o) |=> !status_o);
endmodule

// File: rtl/hsf_stretch.sv
module hsf_stretch #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (trig_i)        cnt_q <= CW'(WIDTH);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  assert_pulse_start_R11: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> pulse_o);
  assert_pulse_no_early_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> !$past(trig_i));
endmodule

// File: rtl/hsync_cleaner.sv
module hsync_cleaner #(
  parameter int PH_W    = 12,
  parameter int WIN_W   = 8,
  parameter int PULSE_W = 16,
  parameter int LOCK_N  = 4,
  parameter int TOL     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_raw,
  input  logic [WIN_W-1:0] win_units,
  input  logic             use_filtered,
  input  logic             use_regen,
  input  logic             status_clr,
  output logic             sync_to_clk,
  output logic             sync_to_proc,
  output logic             extra_seen
);
  localparam int N_OUT = 2;

  logic            rise, acc, regen_trig, locked;
  logic [PH_W-1:0] ph, period;
  logic [N_OUT-1:0] trig, pulse;

  hsf_rise u_rise (.clk(clk), .rst(rst), .raw_i(sync_raw), .rise_o(rise));

  hsf_lock #(.PH_W(PH_W), .LOCK_N(LOCK_N), .TOL(TOL)) u_lock (
    .clk(clk), .rst(rst), .edge_i(acc), .ph_i(ph),
    .locked_o(locked), .period_o(period));

  hsf_track #(.PH_W(PH_W), .WIN_W(WIN_W)) u_track (
    .clk(clk), .rst(rst), .rise_i(rise), .win_i(win_units),
    .locked_i(locked), .period_i(period), .clr_i(status_clr),
    .ph_o(ph), .acc_o(acc), .regen_trig_o(regen_trig), .status_o(extra_seen));

  // index 0: filtered, index 1: flywheel
  assign trig = {regen_trig, acc};

  for (genvar g = 0; g < N_OUT; g++) begin : g_st
    hsf_stretch #(.WIDTH(PULSE_W)) u_st (
      .clk(clk), .rst(rst), .trig_i(trig[g]), .pulse_o(pulse[g]));
  end

  assign sync_to_clk  = use_filtered ? pulse[0] : sync_raw;
  assign sync_to_proc = use_regen    ? pulse[1] : sync_raw;

  assert_regen_locked_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse[1]) |-> locked);
endmodule

// File: tb/sim_hsync_cleaner.sv
`timescale 1ns/1ps
module sim_hsync_cleaner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, sync_raw = 1'b0, use_filtered = 1'b1, use_regen = 1'b1, status_clr = 1'b0;
  logic [7:0] win_units = 8'd10;
  logic       sync_to_clk, sync_to_proc, extra_seen;

  hsync_cleaner u0 (
    .clk(clk), .rst(rst), .sync_raw(sync_raw), .win_units(win_units),
    .use_filtered(use_filtered), .use_regen(use_regen), .status_clr(status_clr),
    .sync_to_clk(sync_to_clk), .sync_to_proc(sync_to_proc), .extra_seen(extra_seen));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int f_rises = 0, f_rise = 0, f_run = 0, f_len = 0;
  int r_rises = 0, r_rise = 0, r_run = 0, r_len = 0;
  logic f_prev = 1'b0, r_prev = 1'b0;

  always @(posedge clk) begin
    #1;
    if (sync_to_clk && !f_prev) begin f_rises++; f_rise = cyc; f_run = 1; end
    else if (sync_to_clk) f_run++;
    else if (f_prev) f_len = f_run;
    f_prev = sync_to_clk;
    if (sync_to_proc && !r_prev) begin r_rises++; r_rise = cyc; r_run = 1; end
    else if (sync_to_proc) r_run++;
    else if (r_prev) r_len = r_run;
    r_prev = sync_to_proc;
  end

  int checks = 0, errors = 0;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic fire(int t, bit clr);
    wait_neg(t - 1);
    sync_raw = 1'b1;
    status_clr = clr;
    @(negedge clk);
    status_clr = 1'b0;
    wait_neg(t + 3);
    sync_raw = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int pred_edge(int anchor, int per);
    return anchor + per;
  endfunction

  function automatic int outside_window(int ph, int per, int w);
    return ((ph > w) && (ph + w < per)) ? 1 : 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    @(negedge clk);
    for (int it = 0; it < 4; it++) begin
      int per, x, d, j, e1, fw, an, g, b, s, c, s2, dd, base_r;
      per = 80 + $urandom_range(80);
      x   = 8 + $urandom_range(12);
      d   = 1 + $urandom_range(x - 1);
      j   = $urandom_range(x);
      sync_raw = 1'b0; use_filtered = 1'b1; use_regen = 1'b1;
      win_units = x[7:0];
      do_reset();
      chk(sync_to_clk, 0, "R1 filtered low after reset");
      chk(sync_to_proc, 0, "R1 flywheel low after reset");
      chk(extra_seen, 0, "R1 flag low after reset");

      // retrigger while unlocked
      base_r = r_rises;
      e1 = cyc + 5;
      fire(e1, 0);
      fire(e1 + 5, 0);
      wait_neg(e1 + 30);
      chk(f_rise, e1, "R3 filtered starts at edge");
      chk(f_len, 21, "R11 retrigger width");
      chk(r_rises - base_r, 0, "R3 flywheel quiet before lock");

      // lock sequence: five edges, four equal periods
      do_reset();
      base_r = r_rises;
      e1 = cyc + 10;
      for (int k = 0; k < 5; k++) fire(e1 + k * per, 0);
      wait_neg(e1 + 4 * per + 20);
      chk(f_len, 16, "R3 filtered width 16");
      chk(f_rise, e1 + 4 * per, "R3 filtered passes every edge unlocked");
      chk(r_rises - base_r, 0, "R2 no flywheel pulse at locking edge");
      chk(extra_seen, 0, "R3 flag quiet unlocked");

      // missing line: flywheel fires
      fw = pred_edge(e1 + 4 * per, per);
      wait_neg(fw);
      chk(r_rise, fw, "R4 flywheel at predicted start");

      // late edge after missed prediction
      an = fw + d;
      fire(an, 0);
      wait_neg(an + 1);
      chk(f_rise, an, "R7 late edge passes filter");
      chk(extra_seen, 0, "R7 late edge not flagged");

      // early / on-time edge in window
      g = pred_edge(an, per) - j;
      fire(g, 0);
      wait_neg(g);
      chk(r_rise, g, "R5 flywheel restarts at accepted edge (R7 realign)");
      chk(f_rise, g, "R5 filtered at accepted edge");
      chk(r_rises - base_r, 2, "R7 no flywheel pulse for late edge");
      chk(extra_seen, 0, "R5 in-window edge not flagged");

      // spurious mid-line edge
      b = g;
      s = b + per / 2;
      fire(s, 0);
      wait_neg(s);
      chk(extra_seen, outside_window(per / 2, per, x), "R6 flag on out-of-window edge");
      chk(f_rise, b, "R6 out-of-window edge blocked");

      c = pred_edge(b, per);
      wait_neg(c);
      chk(r_rise, c, "R4 phase unaffected by spurious edge");
      wait_neg(c + 20);
      chk(f_rise, b, "R10 filtered low on line without edge");
      chk(extra_seen, 1, "R8 flag sticky");
      status_clr = 1'b1;
      @(negedge clk);
      status_clr = 1'b0;
      chk(extra_seen, 0, "R8 clear pulse");

      // flag set and clear in same cycle
      s2 = c + per / 2;
      fire(s2, 1);
      chk(extra_seen, 1, "R8 set wins over clear");
      dd = pred_edge(c, per);
      wait_neg(dd);
      chk(r_rise, dd, "R4 flywheel keeps spacing");
      status_clr = 1'b1;
      @(negedge clk);
      status_clr = 1'b0;

      // raw routing
      use_filtered = 1'b0;
      use_regen = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        sync_raw = 1'($urandom_range(1));
        #1;
        chk(sync_to_clk, sync_raw, "R9 raw on clock output");
        chk(sync_to_proc, sync_raw, "R9 raw on processing output");
      end
      @(negedge clk);
      sync_raw = 1'b0;
      use_filtered = 1'b1;
      use_regen = 1'b1;
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule